// File: doc/BRIEF.md
# DMA Register File and Interrupt Combiner

This block is the software-visible register interface of a multi-channel DMA controller. It sits on a 32-bit word bus that decodes a 4 KB window. It holds a global configuration word, a sync word and five registers for each channel: source, destination, descriptor pointer, control and configuration. It also answers a read-only identification area at the top of the window. Reads are combinational from the address. Writes take effect on the next rising clock edge.

The transfer engine sends one-cycle set pulses for each channel, one for terminal count and one for error. These pulses set raw flags. Each flag is masked by an enable bit taken from that channel's configuration register. The masked flags drive three interrupt lines: error, terminal count, and their OR. Software reads the raw and masked views and clears flags by writing ones. The software request words read as zero and ignore writes.

Top module: `dma_regfile`

## Requirements
- R1: After reset every flag, the global configuration, the sync word and every channel register are zero, so all reads return zero except the identification bytes, and all three interrupt outputs are low.
- R2: A channel register is addressed at byte offset 0x100 + channel*0x20 + slot*4. The slots are 0 source, 1 destination, 2 descriptor pointer, 3 control and 4 configuration. Writes store all 32 bits and reads return them.
- R3: A channel access with slot 5, 6 or 7, or with a channel index at or above the channel count, is ignored on write and reads zero.
- R4: A set pulse on bit c of the terminal-count or error input sets raw flag c. The flag is visible from the next cycle on in the raw terminal-count word (word 5) or the raw error word (word 6).
- R5: A write to word 2 clears every raw terminal-count flag whose written data bit is 1. A write to word 4 does the same for the error flags. Flags whose written bit is 0 are left unchanged.
- R6: If a clear write and a set pulse hit the same flag in the same cycle, the flag ends up set.
- R7: Channel c's terminal-count enable is bit 15 of its configuration register and its error enable is bit 14. Word 1 reads the masked terminal-count flags, word 3 the masked error flags, and word 0 the OR of the two.
- R8: The error output is high when any masked error flag is set. The terminal-count output is high when any masked terminal-count flag is set. The combined output is high when either of them is high.
- R9: Word 7 reads a bitmap whose bit c equals bit 0 of channel c's configuration register.
- R10: Offsets 0xFE0 to 0xFFC read one byte per word, in this order: 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. The first byte is 0x81 when the block is built with 2 channels.
- R11: Word 12 (global configuration) and word 13 (sync) store all 32 written bits and read them back.
- R12: The other global words (8 to 11 and 14 upward), and offsets outside the global, channel and identification areas, read zero. Writes to them change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset in the window; bits [1:0] are ignored |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| tc_set | input | NCH | Terminal-count set pulses from the engine, one per channel |
| err_set | input | NCH | Error set pulses from the engine, one per channel |
| irq_err | output | 1 | Masked error interrupt |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_any | output | 1 | OR of the two interrupt lines |

## Verification
A software clear of a flag and an engine set pulse for the same flag can land in the same clock cycle. This is the one place where bus writes and engine events interact. The bench drives this case directly: it writes all ones to the clear word in the same cycle as set pulses on chosen bits. It also mixes random clear writes with random set pulses. After each such cycle, the raw words must show the pulsed bits set and only the unpulsed written bits cleared. The interrupt outputs are compared on every cycle against masks computed from the model's configuration words.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [11:0]    bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] err_set,
  output logic           irq_err,
  output logic           irq_tc,
  output logic           irq_any
);
  localparam int NSLOT = 5;
  localparam logic [3:0] NCH4 = 4'(NCH);
  localparam logic [7:0] ID0 = (NCH == 2) ? 8'h81 : 8'h80;

  logic [DW-1:0] chreg [NCH][NSLOT];
  logic [DW-1:0] gcfg, gsync;
  logic [NCH-1:0] tc_raw, err_raw, tc_msk, err_msk, en_map;

  wire       in_glb = bus_addr[11:8] == 4'h0;
  wire       in_ch  = bus_addr[11:8] == 4'h1;
  wire       in_id  = bus_addr[11:5] == 7'h7F;
  wire [5:0] widx   = bus_addr[7:2];
  wire [2:0] ch_idx = bus_addr[7:5];
  wire [2:0] slot   = bus_addr[4:2];
  wire       ch_ok  = in_ch && ({1'b0, ch_idx} < NCH4) && (slot < 3'd5);

  wire [NCH-1:0] tc_clr  = (bus_wr && in_glb && widx == 6'd2) ? bus_wdata[NCH-1:0] : '0;
  wire [NCH-1:0] err_clr = (bus_wr && in_glb && widx == 6'd4) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_raw  <= '0;
      err_raw <= '0;
    end else begin
      tc_raw  <= (tc_raw & ~tc_clr) | tc_set;
      err_raw <= (err_raw & ~err_clr) | err_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcfg  <= '0;
      gsync <= '0;
    end else if (bus_wr && in_glb) begin
      if (widx == 6'd12) gcfg  <= bus_wdata;
      if (widx == 6'd13) gsync <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < NSLOT; r++)
          chreg[c][r] <= '0;
    end else if (bus_wr && ch_ok) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < NSLOT; r++)
          if (ch_idx == 3'(c) && slot == 3'(r))
            chreg[c][r] <= bus_wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_map
    assign tc_msk[c]  = chreg[c][4][15];
    assign err_msk[c] = chreg[c][4][14];
    assign en_map[c]  = chreg[c][4][0];
  end

  wire [NCH-1:0] tc_act  = tc_raw & tc_msk;
  wire [NCH-1:0] err_act = err_raw & err_msk;

  assign irq_tc  = |tc_act;
  assign irq_err = |err_act;
  assign irq_any = |(tc_act | err_act);

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = ID0;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h0A;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (in_id) begin
      bus_rdata = DW'(id_byte(bus_addr[4:2]));
    end else if (ch_ok) begin
      bus_rdata = '0;
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < NSLOT; r++)
          if (ch_idx == 3'(c) && slot == 3'(r))
            bus_rdata = chreg[c][r];
    end else if (in_glb) begin
      case (widx)
        6'd0:  bus_rdata = DW'(tc_act | err_act);
        6'd1:  bus_rdata = DW'(tc_act);
        6'd3:  bus_rdata = DW'(err_act);
        6'd5:  bus_rdata = DW'(tc_raw);
        6'd6:  bus_rdata = DW'(err_raw);
        6'd7:  bus_rdata = DW'(en_map);
        6'd12: bus_rdata = gcfg;
        6'd13: bus_rdata = gsync;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module dma_regfile_chk #(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [11:0]    bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic [NCH-1:0] tc_set,
  input logic [NCH-1:0] err_set,
  input logic [NCH-1:0] tc_raw,
  input logic [NCH-1:0] err_raw,
  input logic           irq_err,
  input logic           irq_tc,
  input logic           irq_any
);
  // R4 R6
  tc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |tc_set |=> ((tc_raw & $past(tc_set)) == $past(tc_set)));
  // R4 R6
  err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |err_set |=> ((err_raw & $past(err_set)) == $past(err_set)));
  // R5
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'd2 && tc_set == '0)
      |=> ((tc_raw & $past(bus_wdata[NCH-1:0])) == '0));
  // R8
  irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_err || irq_tc));
  // R8
  irq_tc_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tc |-> (tc_raw != '0));
  // R8
  irq_err_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (err_raw != '0));
endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tc_set(tc_set), .err_set(err_set),
  .tc_raw(tc_raw), .err_raw(err_raw),
  .irq_err(irq_err), .irq_tc(irq_tc), .irq_any(irq_any)
);

// File: tb/tb_dma_regfile.sv
module tb_dma_regfile;
  localparam int NCH = 8;
  localparam int DW  = 32;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] tc_set = '0, err_set = '0;
  logic irq_err, irq_tc, irq_any;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_ch [NCH][5];
  logic [NCH-1:0] m_tc, m_err;
  logic [31:0] m_gcfg, m_sync;

  always #10 clk = ~clk;

  dma_regfile #(.NCH(NCH), .DW(DW)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (addr %h)", req, act, exp, bus_addr);
    end
  endtask

  function automatic logic [NCH-1:0] m_mask(input int bitn);
    logic [NCH-1:0] m;
    for (int c = 0; c < NCH; c++) m[c] = m_ch[c][4][bitn];
    return m;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [7:0] ids [8];
    int w;
    ids = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a >= 12'hFE0) return 32'(ids[a[4:2]]);
    if (a[11:8] == 4'h1) begin
      if (int'(a[7:5]) < NCH && a[4:2] < 3'd5) return m_ch[a[7:5]][a[4:2]];
      return 0;
    end
    if (a[11:8] != 4'h0) return 0;
    w = int'(a[7:2]);
    case (w)
      0: return 32'((m_tc & m_mask(15)) | (m_err & m_mask(14)));
      1: return 32'(m_tc & m_mask(15));
      3: return 32'(m_err & m_mask(14));
      5: return 32'(m_tc);
      6: return 32'(m_err);
      7: return 32'(m_mask(0));
      12: return m_gcfg;
      13: return m_sync;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    if (a >= 12'hFE0) return "R10";
    if (a[11:8] == 4'h1) return (a[4:2] < 3'd5) ? "R2" : "R3";
    if (a[11:8] != 4'h0) return "R12";
    case (int'(a[7:2]))
      0, 1, 3: return "R7";
      2, 4, 5, 6: return "R5";
      7: return "R9";
      12, 13: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic step(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] ts, input logic [NCH-1:0] es);
    logic [NCH-1:0] tclr, eclr;
    bus_wr = wr; bus_addr = a; bus_wdata = d; tc_set = ts; err_set = es;
    @(posedge clk);
    tclr = '0; eclr = '0;
    if (wr) begin
      if (a[11:8] == 4'h1 && int'(a[7:5]) < NCH && a[4:2] < 3'd5) m_ch[a[7:5]][a[4:2]] = d;
      if (a[11:8] == 4'h0) begin
        if (a[7:2] == 6'd2) tclr = d[NCH-1:0];
        if (a[7:2] == 6'd4) eclr = d[NCH-1:0];
        if (a[7:2] == 6'd12) m_gcfg = d;
        if (a[7:2] == 6'd13) m_sync = d;
      end
    end
    m_tc  = (m_tc & ~tclr) | ts;
    m_err = (m_err & ~eclr) | es;
    @(negedge clk);
    bus_wr = 0; tc_set = '0; err_set = '0;
    #1;
    check("R8 irq_tc", 32'(irq_tc), 32'(|(m_tc & m_mask(15))));
    check("R8 irq_err", 32'(irq_err), 32'(|(m_err & m_mask(14))));
    check("R8 irq_any", 32'(irq_any), 32'(|((m_tc & m_mask(15)) | (m_err & m_mask(14)))));
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp_read(a));
  endtask

  function automatic logic [11:0] rand_addr();
    int k = $urandom_range(0, 3);
    case (k)
      0: return {4'h1, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 2'b00};
      1: return {4'h0, 6'($urandom_range(0, 15)), 2'b00};
      2: return {7'h7F, 3'($urandom_range(0, 7)), 2'b00};
      default: return {10'($urandom), 2'b00};
    endcase
  endfunction

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < NCH; c++) for (int r = 0; r < 5; r++) m_ch[c][r] = '0;
    m_tc = '0; m_err = '0; m_gcfg = '0; m_sync = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_any", 32'(irq_any), 0);
    for (int w = 0; w < 16; w++) rd(12'(w * 4), "R1");
    rd(12'h110, "R1"); rd(12'h1F0, "R1");

    // R10 id bytes
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(i * 4), "R10");

    // R2 R7 R8 R9: enable masks on channel 3
    step(1, 12'h170, 32'h0000_C001, '0, '0);
    rd(12'h170, "R2"); rd(12'h01C, "R9");
    step(0, 12'h0, 0, 8'h08, 8'h08);
    rd(12'h000, "R7"); rd(12'h004, "R7"); rd(12'h00C, "R7");
    check("R8 irq_tc set", 32'(irq_tc), 1);
    // R5 clear only tc
    step(1, 12'h008, 32'hFFFF_FFFF, '0, '0);
    rd(12'h014, "R5"); rd(12'h018, "R5");
    check("R5 irq_tc cleared", 32'(irq_tc), 0);
    // R6 set wins over clear
    step(0, 12'h0, 0, 8'hA5, 8'h5A);
    step(1, 12'h008, 32'hFF, 8'h21, '0);
    rd(12'h014, "R6");
    check("R6 tc raw", bus_rdata, 32'h21);
    step(1, 12'h010, 32'hFF, '0, 8'h42);
    rd(12'h018, "R6");
    check("R6 err raw", bus_rdata, 32'h42);
    // R3 R12 ignored writes
    step(1, 12'h114, 32'hDEAD_BEEF, '0, '0);
    rd(12'h114, "R3"); rd(12'h100, "R3");
    step(1, 12'h020, 32'hFFFF_FFFF, '0, '0);
    rd(12'h020, "R12"); rd(12'h014, "R12");
    step(1, 12'h400, 32'h1234_5678, '0, '0);
    rd(12'h400, "R12");
    // R11
    step(1, 12'h030, 32'h8765_4321, '0, '0);
    step(1, 12'h034, 32'h0F0F_A5A5, '0, '0);
    rd(12'h030, "R11"); rd(12'h034, "R11");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = rand_addr();
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d[15:14] = 2'b11;
      if ($urandom_range(0, 4) == 0) a = ($urandom_range(0, 1) != 0) ? 12'h008 : 12'h010;
      step($urandom_range(0, 1) != 0, a, d,
           ($urandom_range(0, 2) == 0) ? NCH'($urandom) : '0,
           ($urandom_range(0, 2) == 0) ? NCH'($urandom) : '0);
      a = rand_addr();
      rd(a, req_of(a));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end
endmodule